// File: doc/BRIEF.md
# Low-Power Mode Status and Control Register

This block is a single byte-wide register on the CPU's peripheral bus. It records whether the processor has executed its stop or its wait instruction, and it holds two configuration controls. The first decides whether the system clock is gated off during wait mode. The second chooses the counting source for a timer.

The two status flags live in the power-on reset domain. Pin resets and software resets leave them untouched, so firmware that starts after any reset can read them. From the flags it can tell a cold start from a warm restart, and it can see whether a reset ended a low-power mode. Software can only clear a flag, by writing 0 to it. The configuration bits clear on every kind of reset.

The clock-gate output is combinational. It follows the wait-state indication from the core directly, so the system clock is released in the same cycle that the wait state ends.

Top module: `lpm_ctl_reg`

## Requirements
- R1: While power-on reset is high, the register is loaded with 0x00 at each clock edge. A read then returns 0x00, and both control outputs are low.
- R2: A one-cycle stop-execution strobe sets bit 0 (stop flag) at the next clock edge.
- R3: A one-cycle wait-execution strobe sets bit 1 (wait flag) at the next clock edge.
- R4: A hardware reset or a software reset leaves bits 0 and 1 at their previous values. The same reset clears bit 3 and bit 6.
- R5: A bus write with 0 in bit 0 or bit 1 clears that flag. A write with 1 in either bit leaves that flag unchanged.
- R6: If a set strobe and a write that would clear the same flag arrive in the same cycle, the flag ends up 1.
- R7: Bit 3 is writable and reads back. The clock-off output equals wait-active AND bit 3, with no register in between.
- R8: Bit 6 is writable and reads back. The timer-source output follows bit 6 (1 = divided sub-clock, 0 = external pin).
- R9: Bits 2, 4, 5 and 7 always read 0, whatever value was written to them.
- R10: The register answers only at address 0x63. Writes to other addresses are ignored, and reads from other addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| hw_rst_i | input | 1 | Pin (hardware) reset, synchronous, active high |
| sw_rst_i | input | 1 | Software reset, synchronous, active high |
| bus_addr_i | input | 8 | Bus address |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| stop_exec_i | input | 1 | Strobe: stop instruction executed |
| wait_exec_i | input | 1 | Strobe: wait instruction executed |
| wait_active_i | input | 1 | The core is in wait state |
| sysclk_off_o | output | 1 | Gate the system clock off |
| tmr_subclk_o | output | 1 | Timer counts the divided sub-clock |

## Verification
A flag that was lost, cleared or wrongly set shows up on the very next read at 0x63. The same holds for the warm-reset checks, because a read follows each reset pulse directly. A wrong configuration bit appears at once on `tmr_subclk_o`. It also appears on `sysclk_off_o` in the first cycle of `wait_active_i`, because no register sits between them. A wrong address decode shows as nonzero data at another address, or as a changed value at 0x63 after a write to its neighbour.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    localparam int DATA_W      = 8;
    localparam int N_FLAG      = 2;
    localparam int BIT_STOP    = 0;
    localparam int BIT_WAIT    = 1;
    localparam int BIT_CLKOFF  = 3;
    localparam int BIT_TSRC    = 6;

    typedef struct packed {
        logic clk_off_in_wait;
        logic tmr_subclk;
    } lpm_cfg_t;

    function automatic logic [DATA_W-1:0] pack_view(
        input logic [N_FLAG-1:0] flags,
        input lpm_cfg_t          cfg
    );
        logic [DATA_W-1:0] v;
        v              = '0;
        v[BIT_STOP]    = flags[0];
        v[BIT_WAIT]    = flags[1];
        v[BIT_CLKOFF]  = cfg.clk_off_in_wait;
        v[BIT_TSRC]    = cfg.tmr_subclk;
        return v;
    endfunction
endpackage

// File: rtl/lpm_flags.sv
module lpm_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         por_i,
    input  logic         warm_i,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (por_i)          flag_o[g] <= 1'b0;
            else if (warm_i)    flag_o[g] <= flag_o[g];
            else if (set_i[g])  flag_o[g] <= 1'b1;
            else if (clr_i[g])  flag_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/lpm_cfg.sv
module lpm_cfg
    import lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output lpm_cfg_t          cfg_o
);
    always_ff @(posedge clk) begin
        if (rst_i) begin
            cfg_o <= '0;
        end else if (wr_i) begin
            cfg_o.clk_off_in_wait <= wdata_i[BIT_CLKOFF];
            cfg_o.tmr_subclk      <= wdata_i[BIT_TSRC];
        end
    end
endmodule

// File: rtl/lpm_clkgate.sv
module lpm_clkgate (
    input  logic wait_active_i,
    input  logic clk_off_sel_i,
    output logic sysclk_off_o
);
    always_comb sysclk_off_o = wait_active_i & clk_off_sel_i;
endmodule

// File: rtl/lpm_ctl_reg.sv
module lpm_ctl_reg
    import lpm_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h63
) (
    input  logic              clk,
    input  logic              por_i,
    input  logic              hw_rst_i,
    input  logic              sw_rst_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              stop_exec_i,
    input  logic              wait_exec_i,
    input  logic              wait_active_i,
    output logic              sysclk_off_o,
    output logic              tmr_subclk_o
);
    logic              sel;
    logic              wr_hit;
    logic              warm;
    logic [N_FLAG-1:0] set_v;
    logic [N_FLAG-1:0] clr_v;
    logic [N_FLAG-1:0] flag_q;
    lpm_cfg_t          cfg_q;

    always_comb begin
        sel      = (bus_addr_i == REG_ADDR);
        wr_hit   = bus_wr_i & sel;
        warm     = hw_rst_i | sw_rst_i;
        set_v    = {wait_exec_i, stop_exec_i};
        clr_v[0] = wr_hit & ~bus_wdata_i[BIT_STOP];
        clr_v[1] = wr_hit & ~bus_wdata_i[BIT_WAIT];
    end

    lpm_flags #(.N(N_FLAG)) u_flags (
        .clk    (clk),
        .por_i  (por_i),
        .warm_i (warm),
        .set_i  (set_v),
        .clr_i  (clr_v),
        .flag_o (flag_q)
    );

    lpm_cfg u_cfg (
        .clk     (clk),
        .rst_i   (por_i | warm),
        .wr_i    (wr_hit),
        .wdata_i (bus_wdata_i),
        .cfg_o   (cfg_q)
    );

    lpm_clkgate u_gate (
        .wait_active_i (wait_active_i),
        .clk_off_sel_i (cfg_q.clk_off_in_wait),
        .sysclk_off_o  (sysclk_off_o)
    );

    always_comb begin
        bus_rdata_o  = sel ? pack_view(flag_q, cfg_q) : '0;
        tmr_subclk_o = cfg_q.tmr_subclk;
    end
endmodule

// File: rtl/lpm_ctl_reg_chk.sv
module lpm_ctl_reg_chk (
    input logic       clk,
    input logic       por_i,
    input logic       warm,
    input logic       stop_exec_i,
    input logic       wait_exec_i,
    input logic       wait_active_i,
    input logic [1:0] flag_q,
    input logic [1:0] cfg_bits,
    input logic [7:0] bus_rdata_o,
    input logic       sysclk_off_o
);
    a_r1_por_clears: assert property (@(posedge clk)
        por_i |=> (flag_q == 2'b00 && cfg_bits == 2'b00));

    a_r2_stop_sets: assert property (@(posedge clk) disable iff (por_i)
        (stop_exec_i && !warm) |=> flag_q[0]);

    a_r3_wait_sets: assert property (@(posedge clk) disable iff (por_i)
        (wait_exec_i && !warm) |=> flag_q[1]);

    a_r4_warm_keeps_flags: assert property (@(posedge clk) disable iff (por_i)
        warm |=> ($stable(flag_q) && cfg_bits == 2'b00));

    a_r5_stop_no_write_set: assert property (@(posedge clk) disable iff (por_i)
        (!flag_q[0] && !stop_exec_i) |=> !flag_q[0]);

    a_r5_wait_no_write_set: assert property (@(posedge clk) disable iff (por_i)
        (!flag_q[1] && !wait_exec_i) |=> !flag_q[1]);

    a_r7_gate_needs_wait: assert property (@(posedge clk) disable iff (por_i)
        !wait_active_i |-> !sysclk_off_o);

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (por_i)
        (bus_rdata_o & 8'hB4) == 8'h00);
endmodule

bind lpm_ctl_reg lpm_ctl_reg_chk chk_i (
    .clk           (clk),
    .por_i         (por_i),
    .warm          (warm),
    .stop_exec_i   (stop_exec_i),
    .wait_exec_i   (wait_exec_i),
    .wait_active_i (wait_active_i),
    .flag_q        (flag_q),
    .cfg_bits      ({cfg_q.clk_off_in_wait, cfg_q.tmr_subclk}),
    .bus_rdata_o   (bus_rdata_o),
    .sysclk_off_o  (sysclk_off_o)
);

// File: tb/lpm_ctl_reg_tb_top.sv
module lpm_ctl_reg_tb_top;
    logic       clk = 1'b0;
    logic       por_i = 1'b1, hw_rst_i = 1'b0, sw_rst_i = 1'b0;
    logic [7:0] bus_addr_i = 8'h63;
    logic       bus_wr_i = 1'b0;
    logic [7:0] bus_wdata_i = 8'h00;
    logic [7:0] bus_rdata_o;
    logic       stop_exec_i = 1'b0, wait_exec_i = 1'b0, wait_active_i = 1'b0;
    logic       sysclk_off_o, tmr_subclk_o;

    always #5 clk = ~clk;

    lpm_ctl_reg dut_i (
        .clk(clk), .por_i(por_i), .hw_rst_i(hw_rst_i), .sw_rst_i(sw_rst_i),
        .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .stop_exec_i(stop_exec_i),
        .wait_exec_i(wait_exec_i), .wait_active_i(wait_active_i),
        .sysclk_off_o(sysclk_off_o), .tmr_subclk_o(tmr_subclk_o)
    );

    typedef struct {
        logic [7:0] rdata;
        logic       gate;
        logic       tsrc;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // monitor: pops one expectation per cycle, samples at the falling edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (bus_rdata_o !== e.rdata || sysclk_off_o !== e.gate || tmr_subclk_o !== e.tsrc) begin
                n_fail++;
                $display("FAIL %s: got rdata=%02h gate=%0b tsrc=%0b, expected rdata=%02h gate=%0b tsrc=%0b",
                         e.tag, bus_rdata_o, sysclk_off_o, tmr_subclk_o, e.rdata, e.gate, e.tsrc);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
        bus_wr_i = 1'b0; stop_exec_i = 1'b0; wait_exec_i = 1'b0;
        hw_rst_i = 1'b0; sw_rst_i = 1'b0; por_i = 1'b0;
    endtask

    task automatic expect_at(input logic [7:0] addr, input logic [7:0] rd,
                             input logic g, input logic t, input string tag);
        exp_t e;
        bus_addr_i = addr;
        e.rdata = rd; e.gate = g; e.tsrc = t; e.tag = tag;
        q.push_back(e);
        step();
    endtask

    task automatic wr(input logic [7:0] addr, input logic [7:0] d);
        bus_addr_i = addr; bus_wdata_i = d; bus_wr_i = 1'b1;
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        por_i = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        por_i = 1'b0;
        expect_at(8'h63, 8'h00, 0, 0, "R1 power-on value");
        stop_exec_i = 1'b1; step();
        expect_at(8'h63, 8'h01, 0, 0, "R2 stop flag set");
        wait_exec_i = 1'b1; step();
        expect_at(8'h63, 8'h03, 0, 0, "R3 wait flag set");
        wr(8'h63, 8'hFF);
        expect_at(8'h63, 8'h4B, 0, 1, "R9 R8 R5 write all ones");
        wait_active_i = 1'b1;
        expect_at(8'h63, 8'h4B, 1, 1, "R7 gate on in wait");
        wait_active_i = 1'b0;
        expect_at(8'h63, 8'h4B, 0, 1, "R7 gate released");
        hw_rst_i = 1'b1; step();
        expect_at(8'h63, 8'h03, 0, 0, "R4 hw reset keeps flags");
        wr(8'h63, 8'h4B);
        sw_rst_i = 1'b1; step();
        expect_at(8'h63, 8'h03, 0, 0, "R4 sw reset keeps flags");
        wr(8'h63, 8'h02);
        expect_at(8'h63, 8'h02, 0, 0, "R5 clear stop only");
        wr(8'h63, 8'h00);
        expect_at(8'h63, 8'h00, 0, 0, "R5 clear wait");
        stop_exec_i = 1'b1;
        wr(8'h63, 8'h00);
        expect_at(8'h63, 8'h01, 0, 0, "R6 set beats clear");
        wr(8'h62, 8'h48);
        expect_at(8'h63, 8'h01, 0, 0, "R10 other address write ignored");
        expect_at(8'h62, 8'h00, 0, 0, "R10 other address reads zero");
        wr(8'h63, 8'h40);
        expect_at(8'h63, 8'h40, 0, 1, "R8 timer source set");
        wr(8'h63, 8'h08);
        expect_at(8'h63, 8'h08, 0, 0, "R7 bit3 set, no wait");
        wait_active_i = 1'b1;
        expect_at(8'h63, 8'h08, 1, 0, "R7 gate follows wait");
        wait_exec_i = 1'b1; stop_exec_i = 1'b1; step();
        por_i = 1'b1; step();
        expect_at(8'h63, 8'h00, 0, 0, "R1 power-on clears flags");
        wait_active_i = 1'b0;
        step();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule